// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Transmit Sequencer

This block decides when the transmit side of an Ethernet MAC may signal low-power idle (LPI) to the PHY, and when it may send frames again. Software sets a manual LPI request bit, an automatic mode bit and the PHY link-good bit. It also supplies one timer word that packs a wake time in microseconds and a link-stable time in milliseconds. Millisecond and microsecond tick pulses come from outside.

Before LPI may start, the link-good bit must stay high for the link-stable time. When LPI ends, the block holds off transmission for the wake time. In automatic mode, LPI is entered only while the transmit queue is empty with no frame request pending, and a new frame request ends LPI. Four sticky event flags record transmit LPI entry and exit and receive LPI entry and exit, the receive events being taken from the PHY's receive LPI indication. A status read clears all four flags. A summary interrupt is raised while any flag is set.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, tx_lpi, tx_hold, lpi_status and lpi_irq are all zero.
- R2: timer_cfg bits 15:0 give the wake time N in microsecond ticks, and bits 26:16 give the link-stable time L in millisecond ticks.
- R3: With LPI requested and ms_tick high every cycle, tx_lpi rises exactly L+1 cycles after link_up rises, and never while link_up has been low.
- R4: While link_up is low the link-stable count is held at zero, so a short drop restarts the full L+1 delay. link_up falling during LPI ends LPI on the next cycle.
- R5: When LPI ends, tx_hold is high for exactly N+1 cycles when us_tick is high every cycle. It stays high for as long as us_tick stays low.
- R6: With lpi_en set, LPI is entered whatever the queue state. Clearing both lpi_en and auto_tx ends LPI on the next cycle.
- R7: With auto_tx set, LPI is entered only while txq_empty is high and tx_req is low. tx_req high during LPI ends LPI on the next cycle.
- R8: lpi_status bit 0 is set when transmit LPI starts, and bit 1 is set when it ends.
- R9: lpi_status bit 2 is set when rx_lpi_ind rises, and bit 3 is set when it falls.
- R10: stat_rd clears every flag in the next cycle, except a flag whose event happens in the same cycle, which stays set. Without stat_rd, flags never clear.
- R11: lpi_irq is high exactly when any lpi_status bit is high.
- R12: tx_lpi and tx_hold are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| us_tick | input | 1 | One-cycle microsecond pulse |
| lpi_en | input | 1 | Manual LPI request |
| auto_tx | input | 1 | Automatic LPI entry and exit by queue state |
| link_up | input | 1 | PHY link-good status |
| timer_cfg | input | 27 | Packed wake time [15:0] and link-stable time [26:16] |
| txq_empty | input | 1 | Transmit queue empty |
| tx_req | input | 1 | New frame request |
| rx_lpi_ind | input | 1 | Receive LPI indication from the PHY interface |
| stat_rd | input | 1 | Status read strobe |
| tx_lpi | output | 1 | Transmit LPI signalling active |
| tx_hold | output | 1 | Wake period; transmission held off |
| lpi_status | output | 4 | Event flags: tx enter, tx exit, rx enter, rx exit (bits 0 to 3) |
| lpi_irq | output | 1 | Summary LPI interrupt |

## Verification
A sweep over a grid of link-stable and wake times measures the exact entry delay and the exact hold length for each pair. This tells apart off-by-one counting in both timers and any swap of the two timer fields. Further runs cover a link drop before entry and a link drop during LPI, a stalled microsecond tick, and automatic mode with a busy queue and with a pending request. Status reads are placed both alone and in the same cycle as a receive event, to separate the clear from the set priority.

// File: rtl/eee_lpi_pkg.sv
`timescale 1ns/1ps
package eee_lpi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_LINK = 2'd1,
        ST_LPI       = 2'd2,
        ST_WAKE      = 2'd3
    } lpi_state_e;

    // Packed so that tx_enter lands on bit 0 of the status vector.
    typedef struct packed {
        logic rx_leave;
        logic rx_enter;
        logic tx_leave;
        logic tx_enter;
    } lpi_evt_t;

    localparam int EVT_N = $bits(lpi_evt_t);

    // Queue gate for entering LPI: only matters in automatic mode.
    function automatic logic queue_allows_lpi(input logic auto_mode,
                                              input logic q_empty,
                                              input logic req);
        return !auto_mode || (q_empty && !req);
    endfunction

    // Conditions that force the transmitter out of LPI.
    function automatic logic lpi_must_leave(input logic any_en,
                                            input logic link,
                                            input logic auto_mode,
                                            input logic req);
        return !any_en || !link || (auto_mode && req);
    endfunction

endpackage

// File: rtl/eee_tick_timer.sv
`timescale 1ns/1ps
module eee_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick && (cnt != CNT_MAX))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= limit);
endmodule

// File: rtl/eee_tx_seq.sv
`timescale 1ns/1ps
module eee_tx_seq
    import eee_lpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_en,
    input  logic       auto_mode,
    input  logic       link_up,
    input  logic       link_ok,
    input  logic       txq_empty,
    input  logic       tx_req,
    input  logic       wake_done,
    output lpi_state_e state,
    output logic       enter_evt,
    output logic       leave_evt
);
    lpi_state_e nxt;

    always_comb begin
        nxt       = state;
        enter_evt = 1'b0;
        leave_evt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (any_en)
                    nxt = ST_WAIT_LINK;
            end
            ST_WAIT_LINK: begin
                if (!any_en) begin
                    nxt = ST_IDLE;
                end else if (link_ok && queue_allows_lpi(auto_mode, txq_empty, tx_req)) begin
                    nxt       = ST_LPI;
                    enter_evt = 1'b1;
                end
            end
            ST_LPI: begin
                if (lpi_must_leave(any_en, link_up, auto_mode, tx_req)) begin
                    nxt       = ST_WAKE;
                    leave_evt = 1'b1;
                end
            end
            ST_WAKE: begin
                if (wake_done)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/eee_evt_flags.sv
`timescale 1ns/1ps
module eee_evt_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         rd,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else
                flags[i] <= set[i] | (flags[i] & ~rd);
        end
    end
endmodule

// File: rtl/eee_lpi_ctrl.sv
`timescale 1ns/1ps
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int WAKE_W = 16,
    parameter int LS_W   = 11,
    localparam int CFG_W = WAKE_W + LS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             us_tick,
    input  logic             lpi_en,
    input  logic             auto_tx,
    input  logic             link_up,
    input  logic [CFG_W-1:0] timer_cfg,
    input  logic             txq_empty,
    input  logic             tx_req,
    input  logic             rx_lpi_ind,
    input  logic             stat_rd,
    output logic             tx_lpi,
    output logic             tx_hold,
    output logic [3:0]       lpi_status,
    output logic             lpi_irq
);
    localparam int WAKE_LSB = 0;
    localparam int LS_LSB   = WAKE_LSB + WAKE_W;

    logic [WAKE_W-1:0] wake_time;
    logic [LS_W-1:0]   ls_time;
    logic              ls_done, link_ok, wake_done;
    logic              enter_evt, leave_evt, rx_prev;
    lpi_state_e        state;
    lpi_evt_t          evt;
    logic [EVT_N-1:0]  flags;

    assign wake_time = timer_cfg[WAKE_LSB +: WAKE_W];
    assign ls_time   = timer_cfg[LS_LSB +: LS_W];

    eee_tick_timer #(.W(LS_W)) u_link_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .clear (!link_up),
        .limit (ls_time),
        .done  (ls_done)
    );
    assign link_ok = link_up && ls_done;

    eee_tick_timer #(.W(WAKE_W)) u_wake_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (us_tick),
        .clear (state != ST_WAKE),
        .limit (wake_time),
        .done  (wake_done)
    );

    eee_tx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .any_en    (lpi_en || auto_tx),
        .auto_mode (auto_tx),
        .link_up   (link_up),
        .link_ok   (link_ok),
        .txq_empty (txq_empty),
        .tx_req    (tx_req),
        .wake_done (wake_done),
        .state     (state),
        .enter_evt (enter_evt),
        .leave_evt (leave_evt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rx_prev <= 1'b0;
        else
            rx_prev <= rx_lpi_ind;
    end

    always_comb begin
        evt.tx_enter = enter_evt;
        evt.tx_leave = leave_evt;
        evt.rx_enter = rx_lpi_ind && !rx_prev;
        evt.rx_leave = !rx_lpi_ind && rx_prev;
    end

    eee_evt_flags #(.N(EVT_N)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (evt),
        .rd    (stat_rd),
        .flags (flags)
    );

    assign tx_lpi     = (state == ST_LPI);
    assign tx_hold    = (state == ST_WAKE);
    assign lpi_status = flags;
    assign lpi_irq    = |flags;
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       link_up,
    input logic       rx_lpi_ind,
    input logic       stat_rd,
    input logic       tx_lpi,
    input logic       tx_hold,
    input logic [3:0] lpi_status
);
    a_r12_lpi_hold_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(tx_lpi && tx_hold));

    a_r3_entry_needs_link: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_lpi) |-> $past(link_up));

    a_r4_link_drop_exit: assert property (@(posedge clk) disable iff (rst)
        (tx_lpi && !link_up) |=> !tx_lpi);

    a_r8_entry_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_lpi) |-> lpi_status[0]);

    a_r8_exit_flag_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_lpi) |-> (tx_hold && lpi_status[1]));

    a_r9_rx_enter_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_lpi_ind && !$past(rx_lpi_ind)) |=> lpi_status[2]);

    a_r10_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((lpi_status & $past(lpi_status)) == $past(lpi_status)));
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .rx_lpi_ind (rx_lpi_ind),
    .stat_rd    (stat_rd),
    .tx_lpi     (tx_lpi),
    .tx_hold    (tx_hold),
    .lpi_status (lpi_status)
);

// File: tb/eee_lpi_ctrl_test.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b1, us_tick = 1'b1;
    logic        lpi_en = 1'b0, auto_tx = 1'b0, link_up = 1'b0;
    logic [26:0] timer_cfg = '0;
    logic        txq_empty = 1'b1, tx_req = 1'b0, rx_lpi_ind = 1'b0, stat_rd = 1'b0;
    logic        tx_lpi, tx_hold, lpi_irq;
    logic [3:0]  lpi_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    eee_lpi_ctrl uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .us_tick(us_tick),
        .lpi_en(lpi_en), .auto_tx(auto_tx), .link_up(link_up),
        .timer_cfg(timer_cfg), .txq_empty(txq_empty), .tx_req(tx_req),
        .rx_lpi_ind(rx_lpi_ind), .stat_rd(stat_rd),
        .tx_lpi(tx_lpi), .tx_hold(tx_hold), .lpi_status(lpi_status),
        .lpi_irq(lpi_irq)
    );

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [26:0] cfg(input int ls, input int wk);
        return {ls[10:0], wk[15:0]};
    endfunction

    // Count cycles until tx_lpi rises (bounded).
    task automatic wait_lpi(output int n);
        n = 0;
        while (!tx_lpi && n < 100) begin
            step();
            n++;
        end
    endtask

    // Count samples with tx_hold high (bounded).
    task automatic count_hold(output int n);
        n = 0;
        while (tx_hold && n < 100) begin
            n++;
            step();
        end
    endtask

    task automatic quiesce();
        lpi_en = 0; auto_tx = 0; link_up = 0; tx_req = 0; us_tick = 1;
        for (int i = 0; i < 80 && (tx_hold || tx_lpi); i++) step();
        step();
        stat_rd = 1; step(); stat_rd = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) step();
        // R1 reset values
        chk("R1 tx_lpi", tx_lpi, 0);
        chk("R1 tx_hold", tx_hold, 0);
        chk("R1 status", lpi_status, 0);
        chk("R1 irq", lpi_irq, 0);
        rst = 0;
        step();

        // R2/R3/R5 sweep of link-stable and wake times
        for (int ls = 0; ls < 5; ls++) begin
            for (int wk = 0; wk < 5; wk++) begin
                quiesce();
                timer_cfg = cfg(ls, wk);
                lpi_en = 1;
                step(); step();
                link_up = 1;
                wait_lpi(n);
                chk("R3 R2 entry delay", n, ls + 1);
                lpi_en = 0;
                step();
                chk("R6 leave on clear", tx_lpi, 0);
                count_hold(n);
                chk("R5 R2 wake length", n, wk + 1);
            end
        end

        // R4 short link drop restarts the count
        quiesce();
        timer_cfg = cfg(3, 1);
        lpi_en = 1;
        step(); step();
        link_up = 1; step(); step();
        link_up = 0; step();
        chk("R4 no entry while low", tx_lpi, 0);
        link_up = 1;
        wait_lpi(n);
        chk("R4 restart delay", n, 4);
        // R4 link drop during LPI
        link_up = 0;
        step();
        chk("R4 drop leaves lpi", tx_lpi, 0);
        chk("R4 drop into hold", tx_hold, 1);
        chk("R8 exit flag", lpi_status[1], 1);

        // R5 stalled microsecond tick
        quiesce();
        timer_cfg = cfg(0, 2);
        lpi_en = 1; step(); step();
        link_up = 1; wait_lpi(n);
        us_tick = 0; lpi_en = 0;
        repeat (12) step();
        chk("R5 hold without tick", tx_hold, 1);
        us_tick = 1;
        count_hold(n);
        chk("R5 hold after tick", n, 3);

        // R7 automatic mode
        quiesce();
        timer_cfg = cfg(0, 0);
        auto_tx = 1; txq_empty = 0; link_up = 1;
        repeat (10) step();
        chk("R7 busy queue blocks", tx_lpi, 0);
        txq_empty = 1; tx_req = 1;
        repeat (5) step();
        chk("R7 pending req blocks", tx_lpi, 0);
        tx_req = 0;
        step();
        chk("R7 entry when idle", tx_lpi, 1);
        chk("R8 entry flag", lpi_status, 4'b0001);
        chk("R11 irq set", lpi_irq, 1);
        tx_req = 1;
        step();
        chk("R7 req leaves lpi", tx_lpi, 0);
        chk("R12 hold not lpi", tx_hold, 1);
        chk("R8 entry and exit", lpi_status, 4'b0011);
        tx_req = 0; auto_tx = 0;

        // R6 manual mode ignores the queue
        quiesce();
        timer_cfg = cfg(0, 0);
        txq_empty = 0; tx_req = 1; lpi_en = 1; link_up = 1;
        wait_lpi(n);
        chk("R6 manual entry", tx_lpi, 1);
        step();
        chk("R6 req ignored in manual", tx_lpi, 1);
        tx_req = 0; txq_empty = 1;

        // R10 read clears, R9 rx flags
        quiesce();
        chk("R10 read clears", lpi_status, 0);
        chk("R11 irq clear", lpi_irq, 0);
        rx_lpi_ind = 1; stat_rd = 1;
        step();
        stat_rd = 0;
        chk("R10 R9 set wins over read", lpi_status, 4'b0100);
        rx_lpi_ind = 0;
        step();
        chk("R9 rx exit flag", lpi_status, 4'b1100);
        repeat (4) step();
        chk("R10 flags sticky", lpi_status, 4'b1100);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R10 read clears rx", lpi_status, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule